// File: doc/BRIEF.md
# Partitioned 128-bit SIMD ALU

This block is the vector arithmetic stage of a wide integer datapath. It takes two 128-bit source operands and a 4-bit operation code. For lane-wise operations it also takes a 2-bit lane-width selector. It returns one 128-bit result together with a destination register index and a write-enable. The operands are read from a register file, and the result is written back to it.

Add, subtract and both compares work on independent lanes of 8, 16, 32 or 64 bits. The upper and lower 64-bit halves are handled in exactly the same way. The four bitwise operations ignore the lane width and act on all 128 bits. A compare fills each lane with all ones when its condition holds and with all zeros when it does not. The index value 0 stands for a hard-wired zero register, so a result aimed at index 0 is dropped. The result, the valid flag and the write-enable leave through one register stage.

Top module: `simd_alu`

## Requirements
- R1: After reset, outValid and outWrEn are low and outData is all zeros.
- R2: outValid is high in the cycle after a cycle with inValid high, and low in the cycle after a cycle with inValid low. outDst then carries the dstIdx that was sampled with that input.
- R3: opCode 0 adds srcA and srcB lane by lane, modulo 2^W, with no carry crossing a lane boundary. The lane width W is 8, 16, 32 or 64 for laneSel 0, 1, 2 or 3.
- R4: opCode 1 subtracts srcB from srcA lane by lane, modulo 2^W, with no borrow crossing a lane boundary.
- R5: opCodes 2, 3, 4 and 5 give AND, OR, XOR and NOR of srcA and srcB over all 128 bits, whatever the value of laneSel.
- R6: opCode 6 sets a lane to all ones when srcA's lane, read as a signed number, is greater than srcB's lane, and to all zeros otherwise.
- R7: opCode 7 sets a lane to all ones when the two lanes are equal, and to all zeros otherwise.
- R8: An accepted input with dstIdx equal to 0 leaves outWrEn low, and outData keeps its previous value.
- R9: opCodes 8 to 15 are reserved. They leave outWrEn low, and outData keeps its previous value.
- R10: outWrEn is never high while outValid is low. For opCodes 0 to 7 with a nonzero dstIdx, outWrEn is high together with outValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and code are valid this cycle |
| opCode | input | 4 | Operation select (see R3 to R9) |
| laneSel | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| srcA | input | 128 | First source operand |
| srcB | input | 128 | Second source operand |
| dstIdx | input | 5 | Destination register index |
| outValid | output | 1 | Registered result slot is valid |
| outWrEn | output | 1 | Write the result to outDst |
| outDst | output | 5 | Destination index echoed |
| outData | output | 128 | Registered result |

## Verification
The bench sweeps every opCode at every lane width over operand patterns built to expose lane leakage. All-ones plus one shows whether a carry runs into the neighbouring lane, and 0x80 against 0x7F shows whether the compare reads lanes as unsigned or picks up its sign from the wrong bit. Equal operands test the equality mask at every width. It also targets the suppressed cases: a write to index 0 or a reserved code that still asserted the write-enable or changed the held data would be caught. So would a bitwise operation that varied with laneSel.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int NUM_WIDTHS = 4;
  localparam int SEL_W      = 2;
  localparam int OP_W       = 4;
  localparam int BASE_LANE  = 8;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_NOR = 4'd5,
    OP_CGT = 4'd6,
    OP_CEQ = 4'd7
  } simdOp_e;

  typedef struct packed {
    logic             load;
    logic             sub;
    logic             useLogic;
    logic [1:0]       logicSel;
    logic             useCmp;
    logic             cmpEq;
    logic [SEL_W-1:0] laneSel;
  } dpCtrl_t;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OP_W-1:0]  opCode,
  input  logic [SEL_W-1:0] laneSel,
  input  logic [IDX_W-1:0] dstIdx,
  output dpCtrl_t          dpCtrl,
  output logic             outValid,
  output logic             outWrEn,
  output logic [IDX_W-1:0] outDst
);
  logic legalOp;
  logic acceptWr;

  assign legalOp  = (opCode[OP_W-1] == 1'b0);
  assign acceptWr = inValid && legalOp && (dstIdx != '0);

  always_comb begin
    dpCtrl          = '0;
    dpCtrl.load     = acceptWr;
    dpCtrl.laneSel  = laneSel;
    case (opCode)
      OP_ADD: dpCtrl.sub = 1'b0;
      OP_SUB: dpCtrl.sub = 1'b1;
      OP_AND: begin dpCtrl.useLogic = 1'b1; dpCtrl.logicSel = 2'd0; end
      OP_OR:  begin dpCtrl.useLogic = 1'b1; dpCtrl.logicSel = 2'd1; end
      OP_XOR: begin dpCtrl.useLogic = 1'b1; dpCtrl.logicSel = 2'd2; end
      OP_NOR: begin dpCtrl.useLogic = 1'b1; dpCtrl.logicSel = 2'd3; end
      OP_CGT: begin dpCtrl.useCmp = 1'b1; dpCtrl.cmpEq = 1'b0; end
      OP_CEQ: begin dpCtrl.useCmp = 1'b1; dpCtrl.cmpEq = 1'b1; end
      default: dpCtrl.sub = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWrEn  <= 1'b0;
      outDst   <= '0;
    end else begin
      outValid <= inValid;
      outWrEn  <= acceptWr;
      if (inValid) outDst <= dstIdx;
    end
  end
endmodule

// File: rtl/simd_dp.sv
module simd_dp
  import simd_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] byWidth [NUM_WIDTHS];
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] nextData;

  for (genvar k = 0; k < NUM_WIDTHS; k++) begin : gWidth
    localparam int W  = BASE_LANE << k;
    localparam int NL = DATA_W / W;
    logic [DATA_W-1:0] widthRes;
    for (genvar i = 0; i < NL; i++) begin : gLane
      logic [W-1:0] laneA, laneB, laneSum;
      logic         gt, eq, hit;
      assign laneA   = srcA[i*W +: W];
      assign laneB   = srcB[i*W +: W];
      assign laneSum = laneA + (dpCtrl.sub ? ~laneB : laneB) + W'(dpCtrl.sub);
      assign gt      = $signed(laneA) > $signed(laneB);
      assign eq      = (laneA == laneB);
      assign hit     = dpCtrl.cmpEq ? eq : gt;
      assign widthRes[i*W +: W] = dpCtrl.useCmp ? {W{hit}} : laneSum;
    end
    assign byWidth[k] = widthRes;
  end

  always_comb begin
    case (dpCtrl.logicSel)
      2'd0:    logicRes = srcA & srcB;
      2'd1:    logicRes = srcA | srcB;
      2'd2:    logicRes = srcA ^ srcB;
      default: logicRes = ~(srcA | srcB);
    endcase
  end

  assign nextData = dpCtrl.useLogic ? logicRes : byWidth[dpCtrl.laneSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outData <= '0;
    else if (dpCtrl.load) outData <= nextData;
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opCode,
  input  logic [1:0]        laneSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IDX_W-1:0]  dstIdx,
  output logic              outValid,
  output logic              outWrEn,
  output logic [IDX_W-1:0]  outDst,
  output logic [DATA_W-1:0] outData
);
  dpCtrl_t dpCtrl;

  simd_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .laneSel(laneSel), .dstIdx(dstIdx), .dpCtrl(dpCtrl),
    .outValid(outValid), .outWrEn(outWrEn), .outDst(outDst)
  );

  simd_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .srcA(srcA), .srcB(srcB),
    .outData(outData)
  );
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] srcA,
  input logic [DATA_W-1:0] srcB,
  input logic [IDX_W-1:0]  dstIdx,
  input logic              outValid,
  input logic              outWrEn,
  input logic [IDX_W-1:0]  outDst,
  input logic [DATA_W-1:0] outData
);
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_dst_echo_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outDst == $past(dstIdx)));
  p_and_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 4'd2 && dstIdx != '0) |=> (outData == ($past(srcA) & $past(srcB))));
  p_zero_dst_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && dstIdx == '0) |=> (!outWrEn && $stable(outData)));
  p_reserved_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode[3]) |=> (!outWrEn && $stable(outData)));
  p_wren_in_slot_r10: assert property (@(posedge clk) disable iff (!rstN)
    outWrEn |-> outValid);
  p_wren_taken_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opCode[3] && dstIdx != '0) |=> outWrEn);
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
  .srcA(srcA), .srcB(srcB), .dstIdx(dstIdx), .outValid(outValid),
  .outWrEn(outWrEn), .outDst(outDst), .outData(outData)
);

// File: tb/tb_simd_alu.sv
module tb_simd_alu;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [3:0]   opCode;
  logic [1:0]   laneSel;
  logic [127:0] srcA, srcB;
  logic [4:0]   dstIdx;
  logic         outValid, outWrEn;
  logic [4:0]   outDst;
  logic [127:0] outData;

  int checks = 0;
  int errors = 0;
  logic [127:0] heldData;

  always #2.5 clk = ~clk;

  simd_alu dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .laneSel(laneSel), .srcA(srcA), .srcB(srcB), .dstIdx(dstIdx),
    .outValid(outValid), .outWrEn(outWrEn), .outDst(outDst), .outData(outData)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string reqFor(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2, 3, 4, 5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [127:0] model(input int op, input int ls,
                                         input logic [127:0] a, input logic [127:0] b);
    int W;
    logic [127:0] r;
    W = 8 << ls;
    r = '0;
    case (op)
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return ~(a | b);
      default: ;
    endcase
    for (int i = 0; i < 128 / W; i++) begin
      logic [63:0] x, y, m, z;
      longint sx, sy;
      m  = (W == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << W) - 64'd1);
      x  = 64'(a >> (i * W)) & m;
      y  = 64'(b >> (i * W)) & m;
      sx = $signed(x << (64 - W)) >>> (64 - W);
      sy = $signed(y << (64 - W)) >>> (64 - W);
      case (op)
        0: z = (x + y) & m;
        1: z = (x - y) & m;
        6: z = (sx > sy) ? m : 64'd0;
        default: z = (x == y) ? m : 64'd0;
      endcase
      r = r | (128'(z) << (i * W));
    end
    return r;
  endfunction

  task automatic issue(input int op, input int ls, input logic [127:0] a,
                       input logic [127:0] b, input logic [4:0] dst);
    logic wr;
    logic [127:0] exp;
    @(negedge clk);
    inValid = 1'b1; opCode = 4'(op); laneSel = 2'(ls);
    srcA = a; srcB = b; dstIdx = dst;
    wr  = (op < 8) && (dst != 5'd0);
    exp = wr ? model(op, ls, a, b) : heldData;
    @(posedge clk);
    #1;
    check("R2 valid", 128'(outValid), 128'd1);
    check("R2 dst", 128'(outDst), 128'(dst));
    if (dst == 5'd0) begin
      check("R8 wren", 128'(outWrEn), 128'd0);
      check("R8 hold", outData, exp);
    end else begin
      check({"R10 wren ", reqFor(op)}, 128'(outWrEn), 128'(wr));
      check(reqFor(op), outData, exp);
    end
    heldData = exp;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  function automatic logic [127:0] pattern(input int p);
    case (p)
      0: return {16{8'hFF}};
      1: return {16{8'h01}};
      2: return {16{8'h80}};
      3: return {16{8'h7F}};
      4: return 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
      5: return 128'h8000_0000_7FFF_FFFF_0000_8000_FFFF_7FFF;
      default: return {4{32'(p * 32'h9E37_79B9)}} ^ {32'(p), 96'h5A5A_A5A5_1234_8765_C3C3_3C3C};
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; opCode = '0; laneSel = '0;
    srcA = '0; srcB = '0; dstIdx = '0;
    heldData = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", 128'(outValid), 128'd0);
    check("R1 wren", 128'(outWrEn), 128'd0);
    check("R1 data", outData, 128'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R2 idle", 128'(outValid), 128'd0);

    // Full sweep: every code, every lane width, boundary and mixed operand pairs
    for (int op = 0; op < 16; op++)
      for (int ls = 0; ls < 4; ls++)
        for (int p = 0; p < 10; p++) begin
          issue(op, ls, pattern(p), pattern((p * 3 + 1) % 10), 5'(1 + (p % 31)));
          issue(op, ls, pattern(p), pattern(p), 5'd7);
        end

    // Carry and borrow isolation at every width
    for (int ls = 0; ls < 4; ls++) begin
      issue(0, ls, {16{8'hFF}}, {16{8'h01}}, 5'd3);   // R3
      issue(1, ls, 128'd0, {16{8'h01}}, 5'd3);         // R4
      issue(6, ls, {16{8'h80}}, {16{8'h7F}}, 5'd3);   // R6
      issue(7, ls, 128'h1, 128'h0, 5'd3);              // R7
    end

    // Suppressed writes: index 0 and reserved codes keep data held
    issue(0, 0, pattern(4), pattern(5), 5'd9);
    for (int op = 0; op < 16; op++) issue(op, op % 4, pattern(6), pattern(2), 5'd0);  // R8
    for (int op = 8; op < 16; op++) issue(op, 0, pattern(7), pattern(8), 5'd12);      // R9

    @(posedge clk); #1;
    check("R2 idle end", 128'(outValid), 128'd0);
    check("R10 idle wren", 128'(outWrEn), 128'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule